// File: doc/BRIEF.md
# Pointer-Indexed Register File Front End

This block sits between a host bus and two independent banks of 8-bit registers: a DMA bank and a serial-controller bank. The bus has no address lines. Each bank is reached through its own chip-select, plus shared read and write strobes and an 8-bit data bus. Every bank keeps a 5-bit pointer in the low bits of its register 0, the command/address register.

To reach any register other than register 0, the host makes two accesses. First it writes the register number into register 0. The next read or write to that same bank then goes to the chosen register. After any access to a bank, that bank's pointer falls back to zero. Register 0 is therefore reachable in one access.

The two pointers are fully separate. A pointer loaded for one bank survives any number of accesses to the other bank.

Top module: `ptrrf_front`

## Requirements
- R1: After reset both pointers are zero, every register of both banks reads 0x00, and register 0 of each bank reads 0x00.
- R2: A write to a bank whose pointer is zero loads the pointer from data bits 4:0 and stores data bits 7:5 as command bits. A read of register 0 returns the command bits in bits 7:5 and zero in bits 4:0.
- R3: A write to a bank whose pointer is nonzero stores the full data byte in the pointed register, does not reload the pointer, and clears the pointer to zero.
- R4: A read of a bank whose pointer is nonzero returns the pointed register, and the pointer is zero for the next access.
- R5: With the pointer at zero, a read returns register 0 directly, and repeated reads keep returning register 0.
- R6: Each bank has its own pointer and its own 32 registers. Accesses to one bank never change the other bank's pointer or registers, however many accesses are made.
- R7: Read data is driven combinationally while the read strobe and exactly one chip-select are active. Otherwise it is 0x00, including during a write.
- R8: A cycle with both chip-selects active is ignored: no pointer, command bit or register changes in either bank. Strobes with no chip-select active are also ignored.
- R9: A cycle with both the read and write strobes active is handled as a write only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge that ends a strobed cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_dma | input | 1 | Chip-select of the DMA bank, active high |
| sel_ser | input | 1 | Chip-select of the serial-controller bank, active high |
| rd_stb | input | 1 | Read strobe, active high, one access per clock cycle |
| wr_stb | input | 1 | Write strobe, active high, one access per clock cycle |
| wdata | input | 8 | Write data; bits 4:0 are the pointer when register 0 is written |
| rdata | output | 8 | Read data of the selected bank, zero when no valid read |

## Verification
The hardest state to reach from the ports is a bank with a pointer still armed while traffic goes to the other bank, or while an illegal cycle occurs. That covers both chip-selects active together, or read and write strobes active together.

The stimulus loads a pointer, then makes a chain of accesses to the other bank or an illegal cycle, and only then makes the pending access. Command bits are first set to a known nonzero value. This lets a wrongly cleared or wrongly reloaded pointer show up as a different value read back, instead of matching a register that happens to be zero.

// File: rtl/ptrrf_pkg.sv
package ptrrf_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int NUM_REG_DEF = 32;
  localparam int NUM_BANK = 2;

  typedef enum logic [0:0] {
    BANK_DMA = 1'b0,
    BANK_SER = 1'b1
  } bank_e;
endpackage

// File: rtl/ptrrf_rst_sync.sv
module ptrrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ptrrf_bank.sv
module ptrrf_bank #(
  parameter int DATA_W  = 8,
  parameter int NUM_REG = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_wr,
  input  logic                       acc_rd,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic [$clog2(NUM_REG)-1:0] ptr_o
);
  localparam int PW = $clog2(NUM_REG);
  localparam int CW = DATA_W - PW;

  logic [PW-1:0]     ptr_q, ptr_d;
  logic [CW-1:0]     cmd_q, cmd_d;
  logic              step_en;
  logic              mem_we;
  logic              ptr_zero;
  logic [DATA_W-1:0] mem_q [NUM_REG];

  assign ptr_zero = (ptr_q == '0);
  assign step_en  = acc_wr | acc_rd;

  // next-state: register 0 write loads pointer, any other access consumes it
  always_comb begin
    ptr_d  = ptr_q;
    cmd_d  = cmd_q;
    mem_we = 1'b0;
    if (acc_wr) begin
      if (ptr_zero) begin
        cmd_d = wdata[DATA_W-1:PW];
        ptr_d = wdata[PW-1:0];
      end else begin
        mem_we = 1'b1;
        ptr_d  = '0;
      end
    end else if (acc_rd) begin
      ptr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cmd_q <= '0;
    end else if (step_en) begin
      ptr_q <= ptr_d;
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REG; i++) begin
        mem_q[i] <= '0;
      end
    end else if (mem_we) begin
      mem_q[ptr_q] <= wdata;
    end
  end

  assign rdata = ptr_zero ? {cmd_q, {PW{1'b0}}} : mem_q[ptr_q];
  assign ptr_o = ptr_q;
endmodule

// File: rtl/ptrrf_front.sv
module ptrrf_front #(
  parameter int DATA_W  = ptrrf_pkg::DATA_W_DEF,
  parameter int NUM_REG = ptrrf_pkg::NUM_REG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_dma,
  input  logic              sel_ser,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import ptrrf_pkg::*;

  localparam int PW = $clog2(NUM_REG);

  logic                  rst_n_int;
  logic                  one_sel;
  logic                  wr_ok;
  logic                  rd_ok;
  logic [NUM_BANK-1:0]   sel_vec;
  logic [DATA_W-1:0]     bank_rdata [NUM_BANK];
  logic [PW-1:0]         bank_ptr   [NUM_BANK];
  logic [PW-1:0]         ptr_dma;
  logic [PW-1:0]         ptr_ser;

  ptrrf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign sel_vec[BANK_DMA] = sel_dma;
  assign sel_vec[BANK_SER] = sel_ser;
  assign one_sel = sel_dma ^ sel_ser;
  assign wr_ok   = wr_stb & one_sel;
  assign rd_ok   = rd_stb & ~wr_stb & one_sel;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    ptrrf_bank #(
      .DATA_W  (DATA_W),
      .NUM_REG (NUM_REG)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .acc_wr (wr_ok & sel_vec[b]),
      .acc_rd (rd_ok & sel_vec[b]),
      .wdata  (wdata),
      .rdata  (bank_rdata[b]),
      .ptr_o  (bank_ptr[b])
    );
  end

  assign ptr_dma = bank_ptr[BANK_DMA];
  assign ptr_ser = bank_ptr[BANK_SER];

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      rdata = sel_dma ? bank_rdata[BANK_DMA] : bank_rdata[BANK_SER];
    end
  end
endmodule

// File: rtl/ptrrf_front_chk.sv
module ptrrf_front_chk #(
  parameter int DATA_W = 8,
  parameter int PW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_dma,
  input logic              sel_ser,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [PW-1:0]     ptr_dma,
  input logic [PW-1:0]     ptr_ser
);
  AST_PTR_LOAD_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sel_dma && !sel_ser && ptr_dma == '0) |=> (ptr_dma == $past(wdata[PW-1:0]))); // R2

  AST_DMA_PTR_CLEARED_AFTER_USE: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_stb || rd_stb) && sel_dma && !sel_ser && ptr_dma != '0) |=> (ptr_dma == '0)); // R3

  AST_SER_PTR_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && sel_ser && !sel_dma) |=> (ptr_ser == '0)); // R4

  AST_DMA_PTR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_dma) |=> $stable(ptr_dma)); // R6

  AST_SER_PTR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ser) |=> $stable(ptr_ser)); // R6

  AST_DUAL_SELECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_dma && sel_ser) |=> ($stable(ptr_dma) && $stable(ptr_ser))); // R8

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && !wr_stb && (sel_dma ^ sel_ser)) |-> (rdata == '0)); // R7
endmodule

bind ptrrf_front ptrrf_front_chk #(
  .DATA_W (DATA_W),
  .PW     (PW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_dma (sel_dma),
  .sel_ser (sel_ser),
  .rd_stb  (rd_stb),
  .wr_stb  (wr_stb),
  .wdata   (wdata),
  .rdata   (rdata),
  .ptr_dma (ptr_dma),
  .ptr_ser (ptr_ser)
);

// File: tb/sim_ptrrf_front.sv
module sim_ptrrf_front;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic       clk;
  logic       rst_n;
  logic       sel_dma;
  logic       sel_ser;
  logic       rd_stb;
  logic       wr_stb;
  logic [7:0] wdata;
  logic [7:0] rdata;

  int n_chk;
  int n_bad;
  bit done;

  ptrrf_front u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_dma (sel_dma),
    .sel_ser (sel_ser),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .wdata   (wdata),
    .rdata   (rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic idle();
    sel_dma = 1'b0;
    sel_ser = 1'b0;
    rd_stb  = 1'b0;
    wr_stb  = 1'b0;
    wdata   = 8'h00;
  endtask

  // bank 0 = DMA, bank 1 = serial
  task automatic bus_wr(input bit bank, input logic [7:0] d);
    @(negedge clk);
    sel_dma = ~bank;
    sel_ser = bank;
    wr_stb  = 1'b1;
    wdata   = d;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic bus_rd(input bit bank, output logic [7:0] d);
    @(negedge clk);
    sel_dma = ~bank;
    sel_ser = bank;
    rd_stb  = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 rdata idle after reset", rdata, 8'h00);
    bus_rd(1'b0, v); chk("R1 dma reg0 after reset", v, 8'h00);
    bus_rd(1'b1, v); chk("R1 ser reg0 after reset", v, 8'h00);
    bus_wr(1'b0, 8'h05);
    bus_rd(1'b0, v); chk("R1 dma reg5 after reset", v, 8'h00);
  endtask

  task automatic t_cmd_bits();
    logic [7:0] v;
    bus_wr(1'b0, 8'hA0);
    bus_rd(1'b0, v); chk("R2 cmd bits readable", v, 8'hA0);
    bus_rd(1'b0, v); chk("R5 repeated reg0 read", v, 8'hA0);
    bus_wr(1'b0, 8'hE3);
    bus_rd(1'b0, v); chk("R4 pointed reg3 read", v, 8'h00);
    bus_rd(1'b0, v); chk("R2 reg0 after pointed read", v, 8'hE0);
  endtask

  task automatic t_write_pointed();
    logic [7:0] v;
    bus_wr(1'b0, 8'h07);
    bus_wr(1'b0, 8'h5A);
    bus_rd(1'b0, v); chk("R3 pointer cleared after write", v, 8'h00);
    bus_wr(1'b0, 8'h07);
    bus_rd(1'b0, v); chk("R4 reg7 holds written byte", v, 8'h5A);
    bus_wr(1'b0, 8'h29);
    bus_wr(1'b0, 8'h03);
    bus_rd(1'b0, v); chk("R3 no reload from pointed write", v, 8'h20);
    bus_wr(1'b0, 8'h09);
    bus_rd(1'b0, v); chk("R3 reg9 holds data", v, 8'h03);
  endtask

  task automatic t_independent();
    logic [7:0] v;
    bus_wr(1'b0, 8'h0C);
    bus_wr(1'b1, 8'h0C);
    bus_wr(1'b1, 8'h77);
    bus_rd(1'b1, v); chk("R6 ser reg0 after ser pointed write", v, 8'h00);
    bus_wr(1'b0, 8'h11);
    bus_wr(1'b0, 8'h0C);
    bus_rd(1'b0, v); chk("R6 dma reg12 kept own value", v, 8'h11);
    bus_wr(1'b1, 8'h0C);
    bus_rd(1'b1, v); chk("R6 ser reg12 kept own value", v, 8'h77);
    bus_wr(1'b1, 8'h4E);
    for (int i = 0; i < 3; i++) begin
      bus_rd(1'b0, v); chk("R6 dma reg0 while ser armed", v, 8'h00);
    end
    bus_wr(1'b1, 8'h99);
    bus_rd(1'b1, v); chk("R6 ser pointer survived dma traffic", v, 8'h40);
    bus_wr(1'b1, 8'h0E);
    bus_rd(1'b1, v); chk("R6 ser reg14 written", v, 8'h99);
  endtask

  task automatic t_rdata_quiet();
    @(negedge clk);
    sel_dma = 1'b1;
    #1 chk("R7 no strobe gives zero", rdata, 8'h00);
    sel_dma = 1'b0;
    rd_stb  = 1'b1;
    #1 chk("R7 no select gives zero", rdata, 8'h00);
    sel_dma = 1'b1;
    sel_ser = 1'b1;
    #1 chk("R8 dual select read gives zero", rdata, 8'h00);
    @(posedge clk);
    #1 idle();
  endtask

  task automatic t_dual_select();
    logic [7:0] v;
    bus_wr(1'b0, 8'h04);
    @(negedge clk);
    sel_dma = 1'b1;
    sel_ser = 1'b1;
    wr_stb  = 1'b1;
    wdata   = 8'h2E;
    @(posedge clk);
    #1 idle();
    @(negedge clk);
    wr_stb = 1'b1;
    wdata  = 8'h3F;
    @(posedge clk);
    #1 idle();
    bus_wr(1'b0, 8'h42);
    bus_wr(1'b0, 8'h04);
    bus_rd(1'b0, v); chk("R8 dma pointer kept over dual select", v, 8'h42);
    bus_rd(1'b1, v); chk("R8 ser untouched by dual select", v, 8'h00);
  endtask

  task automatic t_rd_wr_both();
    logic [7:0] v;
    @(negedge clk);
    sel_dma = 1'b1;
    rd_stb  = 1'b1;
    wr_stb  = 1'b1;
    wdata   = 8'h26;
    #1 chk("R9 no read data during rd+wr", rdata, 8'h00);
    @(posedge clk);
    #1 idle();
    bus_rd(1'b0, v); chk("R9 rd+wr loaded pointer 6", v, 8'h00);
    bus_rd(1'b0, v); chk("R9 rd+wr stored cmd bits", v, 8'h20);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_cmd_bits();
    t_write_pointed();
    t_independent();
    t_rdata_quiet();
    t_dual_select();
    t_rd_wr_both();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule